// File: doc/BRIEF.md
# Accumulator ALU and Instruction Decoder

This block is the execute stage for the accumulator and register subset of a small 8-bit controller. Each cycle in which `valid_i` is high, it decodes a 13-bit instruction word and performs one operation. The operation can move, clear, subtract, decrement, or apply a logic operation between the accumulator and one register. It can also decimal-adjust the accumulator or change the interrupt-enable bit. The block updates the zero (Z), carry (C) and half-carry (DC) flags, and each opcode touches only its own set of flags. Every instruction in the subset takes one cycle. Opcodes outside the subset behave as no-operations.

The register file sits outside the block. The block drives a combinational read address and takes the read data back in the same cycle. It also drives a write port that the file captures on the same clock edge. A 6-bit register field in the instruction picks one of 64 registers in a bank. The bank comes from the two top bits of the bank-select register, which lives at field address 4. That register is held inside the block and is shared by all banks.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator, Z, C, DC, the interrupt-enable bit and the bank-select register (field 4) are all zero.
- R2: A register access uses the address {bank-select[7:6], field}, where the field is instruction bits [5:0]. Field 4 always refers to the internal bank-select register, in every bank. Reads of field 4 return that register, and writes to field 4 update it.
- R3: MOV R,A (0x040|field) writes the accumulator to the register and changes no flag.
- R4: SUB A,R (0x100|field) and SUB R,A (0x140|field) both compute register minus accumulator and send the result to A or to the register respectively. Z is set for a zero result. C=1 when bit 7 produces no borrow. DC=1 when bit 3 produces no borrow.
- R5: DECA R (0x180|field) and DEC R (0x1C0|field) compute register minus 1 into A or into the register respectively, and update only Z.
- R6: OR, AND and XOR take the forms "to A" (0x200, 0x280, 0x300) and "to register" (0x240, 0x2C0, 0x340), each ORed with the field. They update only Z.
- R7: CLRA (0x080) zeroes A and CLR R (0x0C0|field) zeroes the register. Both set Z and leave C and DC unchanged.
- R8: DAA (0x001) works as follows. First 0x06 is added when A[3:0] > 9 or DC=1. Then 0x60 is added when that sum carried out, or its upper nibble is > 9, or C=1. C becomes 1 exactly when the 0x60 is added. Z and DC are unchanged.
- R9: ENI (0x020) sets the interrupt-enable bit and DISI (0x030) clears it. Neither touches a flag.
- R10: An opcode outside the subset, or any cycle with `valid_i` low, changes no state and asserts no write.
- R11: The write port (`we_o`, `wr_addr_o`, `wr_data_o`) is valid combinationally during the instruction's cycle. Accumulator and flag results appear after the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 13 | Instruction word |
| valid_i | input | 1 | Execute `instr_i` this cycle |
| rd_addr_o | output | 8 | Register-file read address {bank, field} |
| rd_data_i | input | 8 | Register-file read data for `rd_addr_o` |
| we_o | output | 1 | Register-file write enable |
| wr_addr_o | output | 8 | Register-file write address |
| wr_data_o | output | 8 | Register-file write data |
| acc_o | output | 8 | Accumulator |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry / no-borrow flag |
| dc_o | output | 1 | Half-carry / no-borrow-from-bit-3 flag |
| ie_o | output | 1 | Interrupt-enable bit |

## Verification
The bench builds the block with its defaults: a 2-bit bank select, a 6-bit field and a 13-bit word. With these, all four banks of 64 registers fit in a 256-entry file model. Random writes to field 4 move the bank select across every bank while the random operand values keep changing. Directed cases cover the 0x00/0xFF and nibble-boundary operands for subtraction and decimal adjust.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int BANK_W = 2,
  parameter int RA_W   = 6,
  parameter int IW     = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [IW-1:0]            instr_i,
  input  logic                     valid_i,
  output logic [BANK_W+RA_W-1:0]   rd_addr_o,
  input  logic [7:0]               rd_data_i,
  output logic                     we_o,
  output logic [BANK_W+RA_W-1:0]   wr_addr_o,
  output logic [7:0]               wr_data_o,
  output logic [7:0]               acc_o,
  output logic                     z_o,
  output logic                     c_o,
  output logic                     dc_o,
  output logic                     ie_o
);
  localparam int GRP_W = IW - RA_W;
  localparam logic [RA_W-1:0] BSEL_FIELD = RA_W'(4);
  localparam logic [IW-1:0] OP_DAA  = IW'(13'h001);
  localparam logic [IW-1:0] OP_ENI  = IW'(13'h020);
  localparam logic [IW-1:0] OP_DISI = IW'(13'h030);
  localparam logic [IW-1:0] OP_CLRA = IW'(13'h080);

  logic [7:0]       bsel;
  logic [GRP_W-1:0] grp;
  logic [RA_W-1:0]  field;
  logic [7:0]       rv, res;
  logic [8:0]       diff;
  logic             to_a, to_r, set_z, set_cdc, is_daa, is_eni, is_disi, is_nop;

  assign grp       = instr_i[IW-1:RA_W];
  assign field     = instr_i[RA_W-1:0];
  assign rd_addr_o = {bsel[7:8-BANK_W], field};
  assign wr_addr_o = rd_addr_o;
  assign rv        = (field == BSEL_FIELD) ? bsel : rd_data_i;
  assign diff      = {1'b0, rv} - {1'b0, acc_o};
  assign is_daa    = instr_i == OP_DAA;
  assign is_eni    = instr_i == OP_ENI;
  assign is_disi   = instr_i == OP_DISI;

  logic       daa_lo, daa_hi;
  logic [8:0] daa_t;
  logic [7:0] daa_r;
  assign daa_lo = (acc_o[3:0] > 4'd9) | dc_o;
  assign daa_t  = {1'b0, acc_o} + (daa_lo ? 9'h006 : 9'h000);
  assign daa_hi = c_o | daa_t[8] | (daa_t[7:4] > 4'd9);
  assign daa_r  = daa_t[7:0] + (daa_hi ? 8'h60 : 8'h00);

  always_comb begin
    res = '0; to_a = 1'b0; to_r = 1'b0; set_z = 1'b0; set_cdc = 1'b0;
    if (instr_i == OP_CLRA) begin
      to_a = 1'b1; set_z = 1'b1;
    end else begin
      case (grp)
        GRP_W'(1):  begin res = acc_o;          to_r = 1'b1; end
        GRP_W'(3):  begin                       to_r = 1'b1; set_z = 1'b1; end
        GRP_W'(4):  begin res = diff[7:0];      to_a = 1'b1; set_z = 1'b1; set_cdc = 1'b1; end
        GRP_W'(5):  begin res = diff[7:0];      to_r = 1'b1; set_z = 1'b1; set_cdc = 1'b1; end
        GRP_W'(6):  begin res = rv - 8'd1;      to_a = 1'b1; set_z = 1'b1; end
        GRP_W'(7):  begin res = rv - 8'd1;      to_r = 1'b1; set_z = 1'b1; end
        GRP_W'(8):  begin res = rv | acc_o;     to_a = 1'b1; set_z = 1'b1; end
        GRP_W'(9):  begin res = rv | acc_o;     to_r = 1'b1; set_z = 1'b1; end
        GRP_W'(10): begin res = rv & acc_o;     to_a = 1'b1; set_z = 1'b1; end
        GRP_W'(11): begin res = rv & acc_o;     to_r = 1'b1; set_z = 1'b1; end
        GRP_W'(12): begin res = rv ^ acc_o;     to_a = 1'b1; set_z = 1'b1; end
        GRP_W'(13): begin res = rv ^ acc_o;     to_r = 1'b1; set_z = 1'b1; end
        default: ;
      endcase
    end
  end

  assign is_nop    = !(to_a | to_r | is_daa | is_eni | is_disi);
  assign we_o      = valid_i & to_r;
  assign wr_data_o = res;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0; z_o <= 1'b0; c_o <= 1'b0; dc_o <= 1'b0; ie_o <= 1'b0; bsel <= '0;
    end else if (valid_i) begin
      if (to_a) acc_o <= res;
      if (set_z) z_o <= (res == 8'd0);
      if (set_cdc) begin
        c_o  <= ~diff[8];
        dc_o <= rv[3:0] >= acc_o[3:0];
      end
      if (is_daa) begin
        acc_o <= daa_r;
        c_o   <= daa_hi;
      end
      if (is_eni) ie_o <= 1'b1;
      if (is_disi) ie_o <= 1'b0;
      if (to_r && field == BSEL_FIELD) bsel <= res;
    end
  end

  a_r10_nop_stable: assert property (@(posedge clk) disable iff (rst)
    (!valid_i || is_nop) |=> ($stable(acc_o) && $stable({z_o, c_o, dc_o, ie_o})));
  a_r3_mov_flags: assert property (@(posedge clk) disable iff (rst)
    (valid_i && grp == GRP_W'(1)) |=> $stable({z_o, c_o, dc_o}));
  a_r4_sub_carry: assert property (@(posedge clk) disable iff (rst)
    (valid_i && grp == GRP_W'(4)) |=> (c_o == ($past(rv) >= $past(acc_o))));
  a_r6_logic_z: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (grp == GRP_W'(8) || grp == GRP_W'(10) || grp == GRP_W'(12)))
      |=> (z_o == (acc_o == 8'd0)) && $stable({c_o, dc_o}));
  a_r7_clr_z: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (instr_i == OP_CLRA || grp == GRP_W'(3))) |=> (z_o && $stable({c_o, dc_o})));
  a_r9_eni: assert property (@(posedge clk) disable iff (rst)
    (valid_i && is_eni) |=> ie_o);
  a_r9_disi: assert property (@(posedge clk) disable iff (rst)
    (valid_i && is_disi) |=> !ie_o);
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic clk = 0, rst = 1, valid = 0;
  logic [12:0] instr = '0;
  logic [7:0] rd_addr, wr_addr, wr_data, acc;
  logic we, z, c, dc, ie;
  logic [7:0] mem [256];
  logic [7:0] rd_data;
  int total = 0, bad = 0;
  logic [7:0] ma, mr4;
  logic mz, mc, mdc, mie;

  always #2 clk = ~clk;
  assign rd_data = mem[rd_addr];

  acc_alu u0 (.clk(clk), .rst(rst), .instr_i(instr), .valid_i(valid),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .we_o(we), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .acc_o(acc), .z_o(z), .c_o(c), .dc_o(dc), .ie_o(ie));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h instr=%h", req, act, exp, instr);
    end
  endtask

  function automatic string tag(input logic [12:0] ins);
    case (ins[12:6])
      7'd1: return "R3"; 7'd3: return "R7"; 7'd4, 7'd5: return "R4";
      7'd6, 7'd7: return "R5"; 7'd8, 7'd9, 7'd10, 7'd11, 7'd12, 7'd13: return "R6";
      default: ;
    endcase
    if (ins == 13'h001) return "R8";
    if (ins == 13'h020 || ins == 13'h030) return "R9";
    if (ins == 13'h080) return "R7";
    return "R10";
  endfunction

  task automatic exec(input logic [12:0] ins, input logic v);
    int g, fld, addr, r, a, t, ewd;
    bit ewe, wa;
    string q;
    @(negedge clk);
    instr = ins; valid = v; q = v ? tag(ins) : "R10";
    fld = ins[5:0]; g = ins[12:6];
    addr = {mr4[7:6], ins[5:0]};
    r = (fld == 4) ? mr4 : mem[addr];
    a = ma; ewe = 0; wa = 0; ewd = 0;
    if (v) begin
      if (ins == 13'h080) begin ma = 0; mz = 1; end
      else if (ins == 13'h001) begin
        t = a;
        if (t % 16 > 9 || mdc) t += 6;
        if (t > 255 || (t / 16) % 16 > 9 || mc) begin t += 96; mc = 1; end else mc = 0;
        ma = t % 256;
      end
      else if (ins == 13'h020) mie = 1;
      else if (ins == 13'h030) mie = 0;
      else if (g >= 1 && g <= 13 && g != 2) begin
        case (g)
          1: ewd = a;
          3: ewd = 0;
          4, 5: ewd = (r - a + 256) % 256;
          6, 7: ewd = (r + 255) % 256;
          8, 9: ewd = r | a;
          10, 11: ewd = r & a;
          default: ewd = r ^ a;
        endcase
        wa = (g == 4 || g == 6 || g == 8 || g == 10 || g == 12);
        ewe = !wa;
        if (g != 1) mz = (ewd == 0);
        if (g == 4 || g == 5) begin mc = (r >= a); mdc = ((r % 16) >= (a % 16)); end
        if (wa) ma = ewd;
      end
    end
    #1;
    chk({q, " R11 we"}, we, ewe);
    if (ewe) begin
      chk({q, " R2 wr_addr"}, wr_addr, addr);
      chk({q, " R11 wr_data"}, wr_data, ewd);
    end
    @(posedge clk); #1;
    if (ewe) begin
      mem[addr] = ewd;
      if (fld == 4) mr4 = ewd;
    end
    chk({q, " acc"}, acc, ma);
    chk({q, " flags zcdc"}, {z, c, dc}, {mz, mc, mdc});
    chk({q, " ie"}, ie, mie);
    valid = 0;
  endtask

  task automatic load_a(input logic [7:0] val);
    mem[{mr4[7:6], 6'd63}] = val;
    exec(13'h080, 1);
    exec(13'h200 | 13'd63, 1);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ops [13] = '{13'h040, 13'h0C0, 13'h100, 13'h140, 13'h180, 13'h1C0, 13'h200,
                     13'h240, 13'h280, 13'h2C0, 13'h300, 13'h340, 13'h000};
    void'($urandom(32'd11));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    ma = 0; mr4 = 0; mz = 0; mc = 0; mdc = 0; mie = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R1 acc", acc, 0);
    chk("R1 flags", {z, c, dc, ie}, 0);
    exec(13'h200 | 13'd4, 1);
    chk("R1 bank reg", acc, 0);
    // R4 boundaries: 0x00-0x01, 0xFF-0x00, equal, nibble borrow
    load_a(8'h01); mem[5] = 8'h00; exec(13'h100 | 13'd5, 1);
    load_a(8'h00); mem[5] = 8'hFF; exec(13'h140 | 13'd5, 1);
    load_a(8'h5A); mem[6] = 8'h5A; exec(13'h100 | 13'd6, 1);
    load_a(8'h0F); mem[6] = 8'h10; exec(13'h100 | 13'd6, 1);
    // R5 decrement wrap
    mem[7] = 8'h00; exec(13'h180 | 13'd7, 1);
    mem[7] = 8'h01; exec(13'h1C0 | 13'd7, 1);
    // R8 decimal adjust corners
    load_a(8'h9A); exec(13'h001, 1);
    load_a(8'h0F); mem[6] = 8'h10; exec(13'h100 | 13'd6, 1); exec(13'h001, 1);
    load_a(8'h99); exec(13'h001, 1);
    load_a(8'hFF); exec(13'h001, 1);
    // R9 and R10
    exec(13'h020, 1); exec(13'h030, 1); exec(13'h020, 1);
    exec(13'h1FFF, 1); exec(13'h0081, 1); exec(13'h100 | 13'd9, 0); exec(13'h0400, 1);
    // R2 bank switch through field 4, then read in new bank
    load_a(8'hC0); exec(13'h040 | 13'd4, 1);
    mem[8'hC9] = 8'h3C; exec(13'h080, 1); exec(13'h200 | 13'd9, 1);
    chk("R2 banked read", acc, 8'h3C);
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom % 17;
      logic [12:0] ins;
      logic [5:0] f = ($urandom % 4 == 0) ? 6'd4 : 6'($urandom);
      if (k < 12) ins = 13'(ops[k]) | {7'd0, f};
      else if (k == 12) ins = 13'h001;
      else if (k == 13) ins = ($urandom % 2) ? 13'h020 : 13'h030;
      else if (k == 14) ins = 13'h080;
      else ins = 13'($urandom);
      exec(ins, ($urandom % 8) != 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule